// File: doc/BRIEF.md
# Filtering Receive Descriptor Engine

This block sits between a receive FIFO and system memory. It pulls 16-bit words from the FIFO, where a flag marks the word that carries end-of-packet status. The first three words of each packet are the destination address; they are compared against a three-word station address kept in a control block in memory. A packet that passes the filter is copied into the buffer described by the descriptor at the head of a linked queue. When the status word arrives, the engine writes back a completion code and the byte length, replaces the queue head with the descriptor's link, and ORs the control block's wakeup mask into a pending-interrupt register.

Packets that fail the filter, that arrive while the queue is empty, or that follow a receiver overrun are drained up to their status word without consuming a descriptor. The control block sits at parameter `CB_BASE`. Its word offsets are: station address at +0..+2, queue head at +3, wakeup mask at +4 and missed-packet counter at +5. A descriptor holds these word offsets: +0 buffer length in bytes, +1 buffer address low, +2 buffer address high, +3 retries (untouched), +4 packet length, +5 completion, +6 link. A head or link value of zero means no descriptor. Memory is a word-addressed port: each request is held until `mem_ack`, and read data is valid in the cycle of the ack.

Top module: `rxq_filter_dma`

## Requirements
- R1: A packet whose first three words equal the control block's station words is accepted, and all of its data words, header included, are written to consecutive addresses starting at the descriptor's buffer address.
- R2: A packet is also accepted whatever its address when bit 15 of the first received word or bit 15 of the first station word is set.
- R3: A packet that fails the filter produces a one-cycle `rx_hunt` pulse and is drained to its status word, with no memory write; the queue head is unchanged.
- R4: If the queue head is zero when a packet passes the filter, the missed-packet counter at control block +5 is incremented, `rx_hunt` pulses, the packet is drained, and no other memory word is written.
- R5: The buffer holds (byte length + 1) / 2 words; no word is ever written at or beyond that many words past the buffer address.
- R6: When the buffer is exactly full, one further data word is discarded without error and the packet completes normally.
- R7: If a second data word arrives after the buffer is full, `rx_hunt` pulses, the packet is drained, and the descriptor is posted with completion 0x8000 and length equal to twice the buffer word capacity.
- R8: The posted length is twice the number of words stored, minus one when the status word's bit 9 (0x0200, odd byte) is set.
- R9: The posted completion equals the status word ANDed with 0xFF00.
- R10: A packet whose computed length is below 14 bytes is discarded: no completion or length is written and the queue head is unchanged.
- R11: A status word with bit 8 (0x0100, receiver overrun) set produces a one-cycle `rx_restart` pulse, and the entire next packet is dropped without any memory write.
- R12: Posting writes the completion and length, writes the descriptor's link into the queue head, and ORs the wakeup mask into `irq_pend`, whose bits stay set until reset.
- R13: Once a post leaves the queue head at zero, later packets are counted as missed until a nonzero head is stored in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | FIFO word available |
| rx_data | input | 16 | FIFO word |
| rx_last | input | 1 | Current word is end-of-packet status |
| rx_ready | output | 1 | Word is consumed at this edge when rx_valid is high |
| rx_hunt | output | 1 | Pulse: receiver told to wait for the next packet start |
| rx_restart | output | 1 | Pulse: receiver turned off and back on after an overrun |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 16 | Read data |
| irq_pend | output | 16 | Accumulated wakeup mask bits |

## Verification
A corrupted address accumulator or length counter shows up at the ports within one packet. The engine either writes into a descriptor it should have left alone, or it leaves the completion, length or queue head fields untouched in memory, and the bench reads those fields back after every packet. A wrong full-buffer state first shows as a write to the guard word just past the buffer, or as a missing 0x8000 completion. A wrong skip flag after an overrun shows as a stray write or a moved queue head during the packet that should have been dropped.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR_RD, ST_HDR_RX, ST_FILTER, ST_HEAD_RD, ST_MISS_RD,
    ST_MISS_WR, ST_DESC_RD, ST_DATA, ST_BUF_WR, ST_DRAIN, ST_NEXT_RD,
    ST_CMP_WR, ST_LEN_WR, ST_HEAD_WR, ST_MASK_RD
  } rxq_state_e;

  // descriptor word offsets
  localparam int unsigned D_BUFLEN = 0;
  localparam int unsigned D_BUFLO  = 1;
  localparam int unsigned D_BUFHI  = 2;
  localparam int unsigned D_PKTLEN = 4;
  localparam int unsigned D_CMPL   = 5;
  localparam int unsigned D_LINK   = 6;
  // control block word offsets
  localparam int unsigned C_HEAD   = 3;
  localparam int unsigned C_MASK   = 4;
  localparam int unsigned C_MISS   = 5;

  localparam logic [15:0] STAT_ODD   = 16'h0200;
  localparam logic [15:0] STAT_OVR   = 16'h0100;
  localparam logic [15:0] STAT_KEEP  = 16'hFF00;
  localparam logic [15:0] CMPL_FULL  = 16'h8000;
  localparam int unsigned MIN_BYTES  = 14;
endpackage

// File: rtl/rxq_host_match.sv
module rxq_host_match #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          upd,
  input  logic          first,
  input  logic [DW-1:0] stored,
  input  logic [DW-1:0] rcvd,
  output logic          hit
);
  logic [DW-1:0] diff_q;
  logic          all_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      diff_q <= '0;
      all_q  <= 1'b0;
    end else if (upd) begin
      diff_q <= diff_q | (stored ^ rcvd);
      if (first) all_q <= stored[DW-1] | rcvd[DW-1];
    end
  end

  assign hit = all_q || (diff_q == '0);

  // a clear always leaves the comparator in the matching state
  assert_clear_matches_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> hit);
endmodule

// File: rtl/rxq_buf_track.sv
module rxq_buf_track #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [LW-1:0] len_bytes,
  input  logic          inc,
  input  logic          discard,
  input  logic          odd,
  output logic [LW-1:0] words,
  output logic          full,
  output logic          crc_used,
  output logic [LW-1:0] bytes,
  output logic [LW-1:0] cap_bytes
);
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cap_q;
  logic          crc_q;
  logic [LW:0]   round_up;

  assign round_up = {1'b0, len_bytes} + {{LW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      cap_q <= '0;
      crc_q <= 1'b0;
    end else begin
      if (load)    cap_q <= round_up[LW:1];
      if (inc)     cnt_q <= cnt_q + 1'b1;
      if (discard) crc_q <= 1'b1;
    end
  end

  assign words     = cnt_q;
  assign full      = (cnt_q == cap_q);
  assign crc_used  = crc_q;
  assign bytes     = {cnt_q[LW-2:0], 1'b0} - {{(LW-1){1'b0}}, odd};
  assign cap_bytes = {cap_q[LW-2:0], 1'b0};

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    inc |-> (cnt_q < cap_q));
  assert_one_discard_R6: assert property (@(posedge clk) disable iff (rst)
    discard |-> (full && !crc_q));
endmodule

// File: rtl/rxq_irq_accum.sv
module rxq_irq_accum #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [MW-1:0] mask,
  output logic [MW-1:0] pend
);
  logic [MW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= '0;
    else if (set_en) pend_q <= pend_q | mask;
  end

  assign pend = pend_q;

  assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/rxq_filter_dma.sv
module rxq_filter_dma
  import rxq_pkg::*;
#(
  parameter int          AW         = 12,
  parameter int          HOST_WORDS = 3,
  parameter logic [AW-1:0] CB_BASE  = 12'h010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [15:0]   rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          rx_hunt,
  output logic          rx_restart,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic [15:0]   irq_pend
);
  localparam int DW = 16;
  localparam int KW = $clog2(HOST_WORDS + 1) < 2 ? 2 : $clog2(HOST_WORDS + 1);

  rxq_state_e    state;
  logic [KW-1:0] k;
  logic [KW-1:0] hdr_idx;
  logic [DW-1:0] hdr [HOST_WORDS];
  logic [DW-1:0] host_w, buf_lo, miss_val, next_ptr, cmpl, pkt_len, wbuf;
  logic [AW-1:0] desc, buf_base;
  logic          skip_next, post_after;

  // submodule wires
  logic          m_hit, m_upd;
  logic          bt_load, bt_inc, bt_discard, bt_odd, bt_full, bt_crc;
  logic [DW-1:0] bt_words, bt_bytes, bt_cap_bytes;
  logic          irq_set;

  // word selection in the data phase
  logic          hdr_pending, word_avail, cur_is_status, data_evt, status_evt;
  logic [DW-1:0] cur_word;
  logic [31:0]   buf_full_addr;

  assign hdr_pending   = (hdr_idx < KW'(HOST_WORDS));
  assign cur_word      = hdr_pending ? hdr[hdr_idx] : rx_data;
  assign word_avail    = hdr_pending || rx_valid;
  assign cur_is_status = !hdr_pending && rx_last;
  assign data_evt      = (state == ST_DATA) && word_avail && !cur_is_status;
  assign status_evt    = (state == ST_DATA) && !hdr_pending && rx_valid && rx_last;
  assign buf_full_addr = {mem_rdata, buf_lo};

  assign m_upd      = (state == ST_HDR_RX) && rx_valid && !rx_last;
  assign bt_load    = (state == ST_DESC_RD) && mem_ack && (k == KW'(D_BUFLEN));
  assign bt_inc     = (state == ST_BUF_WR) && mem_ack;
  assign bt_discard = data_evt && bt_full && !bt_crc;
  assign bt_odd     = |(rx_data & STAT_ODD);
  assign irq_set    = (state == ST_MASK_RD) && mem_ack;

  rxq_host_match #(.DW(DW)) u_match (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE), .upd(m_upd),
    .first(k == '0), .stored(host_w), .rcvd(rx_data), .hit(m_hit)
  );

  rxq_buf_track #(.LW(DW)) u_track (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE), .load(bt_load),
    .len_bytes(mem_rdata), .inc(bt_inc), .discard(bt_discard), .odd(bt_odd),
    .words(bt_words), .full(bt_full), .crc_used(bt_crc), .bytes(bt_bytes),
    .cap_bytes(bt_cap_bytes)
  );

  rxq_irq_accum #(.MW(DW)) u_irq (
    .clk(clk), .rst(rst), .set_en(irq_set), .mask(mem_rdata), .pend(irq_pend)
  );

  // FIFO side
  assign rx_ready = (state == ST_HDR_RX) || (state == ST_DRAIN) ||
                    ((state == ST_DATA) && !hdr_pending);

  // memory request decode
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_HDR_RD:  begin mem_req = 1'b1; mem_addr = CB_BASE + AW'(k); end
      ST_HEAD_RD: begin mem_req = 1'b1; mem_addr = CB_BASE + AW'(C_HEAD); end
      ST_MISS_RD: begin mem_req = 1'b1; mem_addr = CB_BASE + AW'(C_MISS); end
      ST_MISS_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = CB_BASE + AW'(C_MISS); mem_wdata = miss_val;
      end
      ST_DESC_RD: begin mem_req = 1'b1; mem_addr = desc + AW'(k); end
      ST_BUF_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = buf_base + bt_words[AW-1:0]; mem_wdata = wbuf;
      end
      ST_NEXT_RD: begin mem_req = 1'b1; mem_addr = desc + AW'(D_LINK); end
      ST_CMP_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc + AW'(D_CMPL); mem_wdata = cmpl;
      end
      ST_LEN_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc + AW'(D_PKTLEN); mem_wdata = pkt_len;
      end
      ST_HEAD_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = CB_BASE + AW'(C_HEAD); mem_wdata = next_ptr;
      end
      ST_MASK_RD: begin mem_req = 1'b1; mem_addr = CB_BASE + AW'(C_MASK); end
      default: ;
    endcase
  end

  // control sequence
  always_ff @(posedge clk) begin
    rx_hunt    <= 1'b0;
    rx_restart <= 1'b0;
    if (rst) begin
      state      <= ST_IDLE;
      k          <= '0;
      hdr_idx    <= '0;
      host_w     <= '0;
      buf_lo     <= '0;
      miss_val   <= '0;
      next_ptr   <= '0;
      cmpl       <= '0;
      pkt_len    <= '0;
      wbuf       <= '0;
      desc       <= '0;
      buf_base   <= '0;
      skip_next  <= 1'b0;
      post_after <= 1'b0;
      for (int i = 0; i < HOST_WORDS; i++) hdr[i] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          k          <= '0;
          post_after <= 1'b0;
          if (rx_valid) begin
            if (skip_next) begin
              skip_next <= 1'b0;
              state     <= ST_DRAIN;
            end else begin
              state <= ST_HDR_RD;
            end
          end
        end
        ST_HDR_RD: if (mem_ack) begin
          host_w <= mem_rdata;
          state  <= ST_HDR_RX;
        end
        ST_HDR_RX: if (rx_valid) begin
          if (rx_last) begin
            if (|(rx_data & STAT_OVR)) begin
              rx_restart <= 1'b1;
              skip_next  <= 1'b1;
            end
            state <= ST_IDLE;
          end else begin
            hdr[k] <= rx_data;
            if (k == KW'(HOST_WORDS - 1)) begin
              state <= ST_FILTER;
            end else begin
              k     <= k + 1'b1;
              state <= ST_HDR_RD;
            end
          end
        end
        ST_FILTER: begin
          if (m_hit) begin
            state <= ST_HEAD_RD;
          end else begin
            rx_hunt <= 1'b1;
            state   <= ST_DRAIN;
          end
        end
        ST_HEAD_RD: if (mem_ack) begin
          if (mem_rdata == '0) begin
            state <= ST_MISS_RD;
          end else begin
            desc  <= mem_rdata[AW-1:0];
            k     <= '0;
            state <= ST_DESC_RD;
          end
        end
        ST_MISS_RD: if (mem_ack) begin
          miss_val <= mem_rdata + 1'b1;
          state    <= ST_MISS_WR;
        end
        ST_MISS_WR: if (mem_ack) begin
          rx_hunt <= 1'b1;
          state   <= ST_DRAIN;
        end
        ST_DESC_RD: if (mem_ack) begin
          if (k == KW'(D_BUFLO)) buf_lo <= mem_rdata;
          if (k == KW'(D_BUFHI)) begin
            buf_base <= buf_full_addr[AW-1:0];
            hdr_idx  <= '0;
            state    <= ST_DATA;
          end else begin
            k <= k + 1'b1;
          end
        end
        ST_DATA: begin
          if (data_evt) begin
            if (hdr_pending) hdr_idx <= hdr_idx + 1'b1;
            if (!bt_full) begin
              wbuf  <= cur_word;
              state <= ST_BUF_WR;
            end else if (bt_crc) begin
              cmpl       <= CMPL_FULL;
              pkt_len    <= bt_cap_bytes;
              post_after <= 1'b1;
              rx_hunt    <= 1'b1;
              state      <= ST_DRAIN;
            end
          end else if (status_evt) begin
            if (|(rx_data & STAT_OVR)) begin
              rx_restart <= 1'b1;
              skip_next  <= 1'b1;
            end
            if (bt_bytes < 16'(MIN_BYTES)) begin
              state <= ST_IDLE;
            end else begin
              cmpl    <= rx_data & STAT_KEEP;
              pkt_len <= bt_bytes;
              state   <= ST_NEXT_RD;
            end
          end
        end
        ST_BUF_WR: if (mem_ack) state <= ST_DATA;
        ST_DRAIN: if (rx_valid && rx_last) begin
          state <= post_after ? ST_NEXT_RD : ST_IDLE;
        end
        ST_NEXT_RD: if (mem_ack) begin
          next_ptr <= mem_rdata;
          state    <= ST_CMP_WR;
        end
        ST_CMP_WR:  if (mem_ack) state <= ST_LEN_WR;
        ST_LEN_WR:  if (mem_ack) state <= ST_HEAD_WR;
        ST_HEAD_WR: if (mem_ack) state <= ST_MASK_RD;
        ST_MASK_RD: if (mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // a request keeps its address until the memory accepts it
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // the hunt command is a single-cycle pulse
  assert_hunt_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rx_hunt |=> !rx_hunt);
  // a restart always arms the drop of the following packet
  assert_restart_arms_skip_R11: assert property (@(posedge clk) disable iff (rst)
    rx_restart |-> skip_next);
  // the FIFO is never read while a memory request is outstanding
  assert_ready_excl_mem_R5: assert property (@(posedge clk) disable iff (rst)
    !(rx_ready && mem_req));
endmodule

// File: tb/rxq_filter_dma_bench.sv
`timescale 1ns/1ps
module rxq_filter_dma_bench;
  localparam int AW = 12;
  localparam logic [AW-1:0] CB = 12'h010;
  localparam logic [15:0] H0 = 16'h0A12, H1 = 16'h3456, H2 = 16'h789A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          rx_valid, rx_last, rx_ready, rx_hunt, rx_restart;
  logic [15:0]   rx_data;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata, irq_pend;

  rxq_filter_dma #(.AW(AW), .CB_BASE(CB)) u_rxq_filter_dma (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .rx_hunt(rx_hunt),
    .rx_restart(rx_restart), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq_pend(irq_pend)
  );

  // memory model with a backdoor port for the bench
  logic [15:0]   mem [0:4095];
  logic          bw_en = 1'b0;
  logic [AW-1:0] bw_a = '0;
  logic [15:0]   bw_d = '0;
  int wr_cnt = 0, hunt_cnt = 0, rst_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (bw_en) begin
      mem[bw_a] <= bw_d;
      mem_ack   <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (rx_hunt)    hunt_cnt <= hunt_cnt + 1;
    if (rx_restart) rst_cnt  <= rst_cnt + 1;
  end

  int checks = 0, fails = 0;
  logic [15:0] pkt [0:63];
  logic [15:0] exp_irq = '0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_a = a; bw_d = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic push(input logic [15:0] w, input logic last);
    rx_valid = 1'b1; rx_data = w; rx_last = last;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic send(input int n, input logic [15:0] st);
    @(negedge clk);
    for (int i = 0; i < n; i++) push(pkt[i], 1'b0);
    push(st, 1'b1);
    repeat (80) @(negedge clk);
  endtask

  function automatic void model(input int n, input int blen, input logic [15:0] st,
                                output bit post, output int len,
                                output logic [15:0] cmp, output int nst);
    int cap;
    cap = (blen + 1) / 2;
    nst = (n < cap) ? n : cap;
    if (n > cap + 1) begin
      post = 1'b1; len = 2 * cap; cmp = 16'h8000;
    end else begin
      len = 2 * nst - int'(st[9]); cmp = st & 16'hFF00; post = (len >= 14);
    end
  endfunction

  task automatic fill(input int n);
    pkt[0] = H0; pkt[1] = H1; pkt[2] = H2;
    for (int i = 3; i < n; i++) pkt[i] = 16'($urandom);
  endtask

  // sets up one descriptor as queue head, sends, and checks the outcome
  task automatic run_pkt(input string tag, input logic [AW-1:0] d, input int blen,
                         input logic [AW-1:0] ba, input logic [15:0] lnk,
                         input logic [15:0] mask, input int n, input logic [15:0] st);
    bit post; int len; logic [15:0] cmp; int nst; int cap;
    cap = (blen + 1) / 2;
    bw(d + 0, 16'(blen)); bw(d + 1, 16'(ba)); bw(d + 2, 16'h0000);
    bw(d + 4, 16'hFFFF); bw(d + 5, 16'hFFFF); bw(d + 6, lnk);
    bw(ba + AW'(cap), 16'hDEAD);
    bw(CB + 3, 16'(d)); bw(CB + 4, mask);
    send(n, st);
    model(n, blen, st, post, len, cmp, nst);
    for (int i = 0; i < nst; i++) chk({tag, " R1 buffer word"}, mem[ba + AW'(i)], pkt[i]);
    chk({tag, " R5 guard"}, mem[ba + AW'(cap)], 16'hDEAD);
    if (post) begin
      exp_irq |= mask;
      chk({tag, " R8 length"}, mem[d + 4], 16'(len));
      chk({tag, " R9 completion"}, mem[d + 5], cmp);
      chk({tag, " R12 head"}, mem[CB + 3], lnk);
    end else begin
      chk({tag, " R10 length kept"}, mem[d + 4], 16'hFFFF);
      chk({tag, " R10 completion kept"}, mem[d + 5], 16'hFFFF);
      chk({tag, " R10 head kept"}, mem[CB + 3], 16'(d));
    end
    chk({tag, " R12 irq"}, irq_pend, exp_irq);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h0, w0, r0;
    void'($urandom(32'd20240611));
    rst = 1'b1; rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset mem_req", 16'(mem_req), 16'h0);
    chk("reset rx_ready", 16'(rx_ready), 16'h0);
    chk("reset irq R12", irq_pend, 16'h0);
    bw(CB + 0, H0); bw(CB + 1, H1); bw(CB + 2, H2); bw(CB + 5, 16'd7);

    // directed: normal accept
    fill(10);
    run_pkt("R1 basic", 12'h100, 40, 12'h400, 16'h0108, 16'h0001, 10, 16'h4000);

    // R6: exactly full plus one discarded word
    fill(9);
    run_pkt("R6 full+crc", 12'h108, 16, 12'h440, 16'h0110, 16'h0002, 9, 16'h5000);
    // R7: overflow
    fill(11);
    run_pkt("R7 overflow", 12'h110, 16, 12'h480, 16'h0118, 16'h0004, 11, 16'h5000);
    // R8: odd byte with odd buffer length
    fill(8);
    run_pkt("R8 odd", 12'h118, 15, 12'h4C0, 16'h0120, 16'h0008, 8, 16'h0200);
    // R10: 12 bytes dropped, 14 bytes posted
    fill(6);
    run_pkt("R10 short", 12'h120, 40, 12'h500, 16'h0128, 16'h0010, 6, 16'h0000);
    fill(7);
    run_pkt("R10 boundary", 12'h128, 40, 12'h540, 16'h0130, 16'h0020, 7, 16'h0000);

    // R2: received first word with top bit, address otherwise wrong
    fill(9); pkt[0] = 16'h8001; pkt[1] = 16'h1111; pkt[2] = 16'h2222;
    run_pkt("R2 rx all", 12'h130, 40, 12'h580, 16'h0138, 16'h0040, 9, 16'h0000);
    // R2: stored first word with top bit
    bw(CB + 0, 16'h8000);
    fill(9); pkt[0] = 16'h0F0F; pkt[1] = 16'h1111;
    run_pkt("R2 stored all", 12'h138, 40, 12'h5C0, 16'h0140, 16'h0080, 9, 16'h0000);
    bw(CB + 0, H0);

    // R3: reject on last address word
    bw(CB + 3, 16'h0140); bw(12'h140 + 5, 16'hFFFF);
    fill(9); pkt[2] = H2 ^ 16'h0001;
    h0 = hunt_cnt; w0 = wr_cnt;
    send(9, 16'h0000);
    chk("R3 hunt pulse", 16'(hunt_cnt - h0), 16'd1);
    chk("R3 no writes", 16'(wr_cnt - w0), 16'd0);
    chk("R3 head kept", mem[CB + 3], 16'h0140);
    chk("R3 completion kept", mem[12'h140 + 5], 16'hFFFF);

    // R4: empty queue
    bw(CB + 3, 16'h0000);
    fill(9);
    h0 = hunt_cnt; w0 = wr_cnt;
    send(9, 16'h0000);
    chk("R4 missed count", mem[CB + 5], 16'd8);
    chk("R4 hunt pulse", 16'(hunt_cnt - h0), 16'd1);
    chk("R4 single write", 16'(wr_cnt - w0), 16'd1);

    // R11: overrun status, next packet dropped, then normal again
    r0 = rst_cnt;
    fill(9);
    run_pkt("R11 overrun post", 12'h140, 40, 12'h600, 16'h0148, 16'h0100, 9, 16'h0100);
    chk("R11 restart pulse", 16'(rst_cnt - r0), 16'd1);
    bw(12'h148 + 0, 16'd40); bw(12'h148 + 1, 16'h0640); bw(12'h148 + 2, 16'h0);
    bw(12'h148 + 5, 16'hFFFF); bw(12'h148 + 6, 16'h0000);
    fill(9);
    w0 = wr_cnt;
    send(9, 16'h0000);
    chk("R11 skipped no writes", 16'(wr_cnt - w0), 16'd0);
    chk("R11 skipped head kept", mem[CB + 3], 16'h0148);
    // R13: descriptor with zero link empties the queue
    fill(9);
    run_pkt("R13 last desc", 12'h148, 40, 12'h640, 16'h0000, 16'h0200, 9, 16'h0000);
    fill(9);
    send(9, 16'h0000);
    chk("R13 missed after empty", mem[CB + 5], 16'd9);
    chk("R13 head stays zero", mem[CB + 3], 16'h0000);

    // random packets
    for (int it = 0; it < 20; it++) begin
      int blen, n;
      logic [15:0] st;
      blen = 6 + int'($urandom % 50);
      n    = 3 + int'($urandom % 30);
      st   = 16'($urandom) & 16'hFEFF;
      fill(n);
      run_pkt("rand R1 R5 R6 R7 R8 R9 R10 R12", AW'(12'h200 + it * 8), blen,
              AW'(12'h800 + it * 64), 16'(12'h300 + it * 8),
              16'(1 << (it % 16)), n, st);
    end

    finish_run();
  end
endmodule